// File: doc/BRIEF.md
# Register-Storage Add Unit

This block runs one kind of instruction: an add whose second operand comes from memory. A 32-bit instruction word is offered with a valid strobe while the unit is idle. The unit splits the word into its fields and forms a 24-bit operand address from a 12-bit displacement and up to two general registers. It then requests a 32-bit big-endian word from memory and waits for the acknowledge. It adds that word to the destination register, writes the sum back into the same register and sets a 2-bit condition code from the result.

The unit holds its own file of sixteen 32-bit general registers. A test port can write any register and read any register back, so the surrounding logic can preload operands and inspect results. Any opcode other than the add opcode is rejected with a one-cycle flag and has no other effect.

Top module: `rx_add_unit`

## Requirements
- R1: The instruction word is split, most significant bit first, as follows: opcode in bits 31:24, destination register R1 in 23:20, index register X2 in 19:16, base register B2 in 15:12, and unsigned displacement D2 in 11:0. The add opcode is 8'h5A.
- R2: The operand address is D2 + GR[B2] + GR[X2], truncated to 24 bits, so it wraps modulo 2^24. A B2 or X2 field of 0 contributes zero, whatever GR0 holds.
- R3: When an add is accepted, mem_req_o rises in the next cycle and mem_addr_o carries the operand address. Both hold steady until mem_ack_i is sampled high, and mem_rdata_i is captured in that same cycle. The word is big-endian: the byte at the operand address sits in bits 31:24 and the byte at address+3 (mod 2^24) sits in bits 7:0.
- R4: done_o pulses for one cycle, in the cycle after the acknowledge. On the following edge GR[R1] becomes GR[R1] + operand mod 2^32, and R1 = 0 is a valid destination.
- R5: cc_o is updated on that same edge: 0 for a zero sum, 1 for a negative sum, 2 for a positive sum, and 3 for signed overflow. On overflow the stored sum still wraps. cc_o does not change at any other time.
- R6: An accepted word whose opcode is not 8'h5A raises illegal_o for exactly the next cycle. It makes no memory request and leaves every register and cc_o unchanged.
- R7: ready_o is high only while the unit is idle, and instructions are accepted only when it is high.
- R8: Reset clears all registers and cc_o to 0 and leaves the unit idle. A test write with tst_we_i updates GR[tst_idx_i] on the next edge. tst_rdata_o shows GR[tst_ridx_i] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| ready_o | output | 1 | Unit idle, can accept an instruction |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Operand byte address |
| mem_ack_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Big-endian operand word |
| done_o | output | 1 | Writeback pulse |
| cc_o | output | 2 | Condition code |
| illegal_o | output | 1 | Unknown opcode pulse |
| tst_we_i | input | 1 | Test register write enable |
| tst_idx_i | input | 4 | Test write register index |
| tst_wdata_i | input | 32 | Test write data |
| tst_ridx_i | input | 4 | Test read register index |
| tst_rdata_o | output | 32 | Test read data |

## Verification
The assertions check the handshake and sequencing rules on every cycle. A request holds its address until acknowledged. done_o follows an acknowledge and lasts one cycle. cc_o moves only at writeback. A rejected opcode never starts a request, and ready_o stays low while an add is in flight. The arithmetic cannot be seen by a per-cycle property, and only the bench scenarios show it: the address sum, including the zero-register rule and the 24-bit wrap, the big-endian operand, the stored sum and the condition-code value for zero, negative, positive and overflow results.

// File: rtl/rx_add_pkg.sv
package rx_add_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WB    = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  r1;
    logic [3:0]  x2;
    logic [3:0]  b2;
    logic [11:0] d2;
  } rx_fields_t;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_POS  = 2'd2;
  localparam logic [1:0] CC_OVF  = 2'd3;
endpackage

// File: rtl/rx_gr_file.sv
module rx_gr_file #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int NRD  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           exe_we_i,
  input  logic [IW-1:0]                  exe_idx_i,
  input  logic [XLEN-1:0]                exe_data_i,
  input  logic                           tst_we_i,
  input  logic [IW-1:0]                  tst_idx_i,
  input  logic [XLEN-1:0]                tst_data_i,
  input  logic [NRD-1:0][IW-1:0]         rd_idx_i,
  output logic [NRD-1:0][XLEN-1:0]       rd_data_o
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  // execution writeback wins over a same-cycle test write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (exe_we_i && exe_idx_i == IW'(i))
          regs_q[i] <= exe_data_i;
        else if (tst_we_i && tst_idx_i == IW'(i))
          regs_q[i] <= tst_data_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = regs_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/rx_agen.sv
module rx_agen #(
  parameter int XLEN = 32,
  parameter int AW   = 24,
  parameter int DW   = 12,
  parameter int IW   = 4
) (
  input  logic [IW-1:0]   b_idx_i,
  input  logic [IW-1:0]   x_idx_i,
  input  logic [XLEN-1:0] b_val_i,
  input  logic [XLEN-1:0] x_val_i,
  input  logic [DW-1:0]   disp_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] b_eff, x_eff, d_ext;
  logic          unused_hi;

  // field value 0 means "no register", not GR0
  assign b_eff  = (b_idx_i == '0) ? '0 : b_val_i[AW-1:0];
  assign x_eff  = (x_idx_i == '0) ? '0 : x_val_i[AW-1:0];
  assign d_ext  = {{(AW-DW){1'b0}}, disp_i};
  assign addr_o = d_ext + b_eff + x_eff;
  assign unused_hi = ^{b_val_i[XLEN-1:AW], x_val_i[XLEN-1:AW]};
endmodule

// File: rtl/rx_add_cc.sv
module rx_add_cc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sum_o,
  output logic [1:0]      cc_o
);
  import rx_add_pkg::*;
  logic ovf;

  assign sum_o = a_i + b_i;
  assign ovf   = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);

  always_comb begin
    if (ovf)                cc_o = CC_OVF;
    else if (sum_o == '0)   cc_o = CC_ZERO;
    else if (sum_o[XLEN-1]) cc_o = CC_NEG;
    else                    cc_o = CC_POS;
  end
endmodule

// File: rtl/rx_add_unit.sv
module rx_add_unit #(
  parameter int          XLEN   = 32,
  parameter int          AW     = 24,
  parameter int          NREG   = 16,
  parameter logic [7:0]  ADD_OP = 8'h5A,
  localparam int         IW     = $clog2(NREG),
  localparam int         DW     = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [31:0]     instr_i,
  output logic            ready_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_ack_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [1:0]      cc_o,
  output logic            illegal_o,
  input  logic            tst_we_i,
  input  logic [IW-1:0]   tst_idx_i,
  input  logic [XLEN-1:0] tst_wdata_i,
  input  logic [IW-1:0]   tst_ridx_i,
  output logic [XLEN-1:0] tst_rdata_o
);
  import rx_add_pkg::*;

  localparam int RP_X = 0;
  localparam int RP_B = 1;
  localparam int RP_D = 2;
  localparam int RP_T = 3;

  rx_state_e              state_q;
  rx_fields_t             fld;
  logic [IW-1:0]          r1_q;
  logic [AW-1:0]          addr_q, addr_d;
  logic [XLEN-1:0]        opnd_q, sum;
  logic [1:0]             cc_q, cc_d;
  logic                   illegal_q;
  logic                   accept, is_add;
  logic [3:0][IW-1:0]     rd_idx;
  logic [3:0][XLEN-1:0]   rd_data;

  assign fld    = rx_fields_t'(instr_i);
  assign accept = instr_valid_i && (state_q == ST_IDLE);
  assign is_add = (fld.op == ADD_OP);

  assign rd_idx[RP_X] = fld.x2;
  assign rd_idx[RP_B] = fld.b2;
  assign rd_idx[RP_D] = r1_q;
  assign rd_idx[RP_T] = tst_ridx_i;

  rx_gr_file #(.NREG(NREG), .XLEN(XLEN), .NRD(4)) i_gr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exe_we_i   (state_q == ST_WB),
    .exe_idx_i  (r1_q),
    .exe_data_i (sum),
    .tst_we_i   (tst_we_i),
    .tst_idx_i  (tst_idx_i),
    .tst_data_i (tst_wdata_i),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data)
  );

  rx_agen #(.XLEN(XLEN), .AW(AW), .DW(DW), .IW(IW)) i_agen (
    .b_idx_i (fld.b2),
    .x_idx_i (fld.x2),
    .b_val_i (rd_data[RP_B]),
    .x_val_i (rd_data[RP_X]),
    .disp_i  (fld.d2),
    .addr_o  (addr_d)
  );

  rx_add_cc #(.XLEN(XLEN)) i_alu (
    .a_i   (rd_data[RP_D]),
    .b_i   (opnd_q),
    .sum_o (sum),
    .cc_o  (cc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      r1_q      <= '0;
      addr_q    <= '0;
      opnd_q    <= '0;
      cc_q      <= CC_ZERO;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !is_add;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && is_add) begin
            r1_q    <= fld.r1;
            addr_q  <= addr_d;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            opnd_q  <= mem_rdata_i;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          cc_q    <= cc_d;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH);
  assign mem_addr_o  = addr_q;
  assign done_o      = (state_q == ST_WB);
  assign cc_o        = cc_q;
  assign illegal_o   = illegal_q;
  assign tst_rdata_o = rd_data[RP_T];
endmodule

// File: rtl/rx_add_checker.sv
module rx_add_checker #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_valid_i,
  input logic          ready_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          done_o,
  input logic [1:0]    cc_o,
  input logic          illegal_o
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_done_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(cc_o));

  p_illegal_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && $past(instr_valid_i && ready_o));

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> !ready_o);
endmodule

bind rx_add_unit rx_add_checker #(.AW(AW)) i_rx_add_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .ready_o       (ready_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ack_i     (mem_ack_i),
  .done_o        (done_o),
  .cc_o          (cc_o),
  .illegal_o     (illegal_o)
);

// File: tb/test_rx_add_unit.sv
`timescale 1ns/1ps
module test_rx_add_unit;
  localparam logic [7:0] ADD = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        ready, mem_req, mem_ack = 1'b0, done, illegal;
  logic [23:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  cc;
  logic        tst_we = 1'b0;
  logic [3:0]  tst_idx = '0, tst_ridx = '0;
  logic [31:0] tst_wdata = '0, tst_rdata;

  int          n_chk = 0, n_bad = 0;
  logic [31:0] sh [16];
  logic [1:0]  sh_cc = 2'd0;
  logic        force_en = 1'b0;
  logic [31:0] force_val = '0;

  always #2.5 clk = ~clk;

  rx_add_unit i_rx_add_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .cc_o(cc), .illegal_o(illegal),
    .tst_we_i(tst_we), .tst_idx_i(tst_idx), .tst_wdata_i(tst_wdata),
    .tst_ridx_i(tst_ridx), .tst_rdata_o(tst_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ (a[23:16] * 8'd3) ^ 8'h5b;
  endfunction

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {mem_byte(a), mem_byte(a + 24'd1), mem_byte(a + 24'd2), mem_byte(a + 24'd3)};
  endfunction

  function automatic logic [1:0] exp_cc(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = a + b;
    if (a[31] == b[31] && s[31] != a[31]) return 2'd3;
    if (s == 0) return 2'd0;
    if (s[31]) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic gr_write(input logic [3:0] idx, input logic [31:0] v);
    @(negedge clk);
    tst_we = 1'b1; tst_idx = idx; tst_wdata = v;
    @(negedge clk);
    tst_we = 1'b0;
    sh[idx] = v;
  endtask

  task automatic gr_check(input logic [3:0] idx, input string req);
    tst_ridx = idx;
    #0.1;
    chk(tst_rdata == sh[idx], req, tst_rdata, sh[idx]);
  endtask

  task automatic run_add(input logic [3:0] r1, input logic [3:0] x2, input logic [3:0] b2,
                         input logic [11:0] d2, input int dly);
    logic [23:0] ea, bv, xv;
    logic [31:0] opnd, a;
    bv = (b2 == 0) ? 24'd0 : sh[b2][23:0];
    xv = (x2 == 0) ? 24'd0 : sh[x2][23:0];
    ea = {12'd0, d2} + bv + xv;
    opnd = force_en ? force_val : mem_word(ea);
    @(negedge clk);
    instr_valid = 1'b1; instr = {ADD, r1, x2, b2, d2};
    @(negedge clk);
    instr_valid = 1'b0;
    chk(mem_req === 1'b1, "R3 req", {31'd0, mem_req}, 32'd1);
    chk(mem_addr === ea, "R2/R1 addr", {8'd0, mem_addr}, {8'd0, ea});
    chk(ready === 1'b0, "R7 busy", {31'd0, ready}, 32'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === ea, "R3 hold", {8'd0, mem_addr}, {8'd0, ea});
    end
    mem_ack = 1'b1; mem_rdata = opnd;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = '0;
    chk(done === 1'b1, "R4 done", {31'd0, done}, 32'd1);
    @(negedge clk);
    a = sh[r1];
    sh_cc = exp_cc(a, opnd);
    sh[r1] = a + opnd;
    chk(done === 1'b0, "R4 pulse", {31'd0, done}, 32'd0);
    chk(cc === sh_cc, "R5 cc", {30'd0, cc}, {30'd0, sh_cc});
    chk(ready === 1'b1, "R7 idle", {31'd0, ready}, 32'd1);
    gr_check(r1, "R4 sum");
  endtask

  task automatic run_illegal(input logic [7:0] op, input logic [3:0] r1);
    @(negedge clk);
    instr_valid = 1'b1; instr = {op, r1, 4'd1, 4'd2, 12'h123};
    @(negedge clk);
    instr_valid = 1'b0;
    chk(illegal === 1'b1, "R6 flag", {31'd0, illegal}, 32'd1);
    chk(mem_req === 1'b0, "R6 no req", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk(illegal === 1'b0, "R6 one cycle", {31'd0, illegal}, 32'd0);
    chk(mem_req === 1'b0 && ready === 1'b1, "R6 idle", {31'd0, mem_req}, 32'd0);
    chk(cc === sh_cc, "R6 cc kept", {30'd0, cc}, {30'd0, sh_cc});
    gr_check(r1, "R6 reg kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) sh[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(ready === 1'b1 && mem_req === 1'b0 && done === 1'b0 && illegal === 1'b0,
        "R8 reset outputs", {28'd0, ready, mem_req, done, illegal}, 32'h8);
    chk(cc === 2'd0, "R8 reset cc", {30'd0, cc}, 32'd0);
    for (int i = 0; i < 16; i++) gr_check(4'(i), "R8 reset reg");

    // R8 test write
    gr_write(4'd7, 32'hDEAD_BEEF);
    gr_check(4'd7, "R8 test write");

    // R2: zero fields ignore GR0
    gr_write(4'd0, 32'h0012_3456);
    run_add(4'd3, 4'd0, 4'd0, 12'hABC, 0);
    // R2: base+index+disp
    gr_write(4'd4, 32'h0000_1000);
    gr_write(4'd5, 32'h0000_0200);
    run_add(4'd6, 4'd5, 4'd4, 12'h034, 2);
    // R2 wrap at 24 bits, upper bits of register ignored; R3 big-endian across wrap
    gr_write(4'd8, 32'hFFFF_FFFE);
    run_add(4'd9, 4'd0, 4'd8, 12'h000, 1);
    gr_write(4'd10, 32'h00FF_FFFF);
    run_add(4'd11, 4'd10, 4'd8, 12'hFFF, 0);
    // R4: R1 = 0 destination
    run_add(4'd0, 4'd0, 4'd0, 12'h010, 3);

    // R5 corner cases with forced operand
    force_en = 1'b1;
    gr_write(4'd12, 32'h7FFF_FFFF); force_val = 32'h0000_0001;
    run_add(4'd12, 4'd0, 4'd0, 12'h0, 0);           // overflow -> 3
    gr_write(4'd12, 32'h8000_0000); force_val = 32'h8000_0000;
    run_add(4'd12, 4'd0, 4'd0, 12'h0, 0);           // overflow to zero -> 3
    gr_write(4'd13, 32'h0000_0005); force_val = 32'hFFFF_FFFB;
    run_add(4'd13, 4'd0, 4'd0, 12'h0, 1);           // zero -> 0
    force_val = 32'hFFFF_FFF0;
    run_add(4'd13, 4'd0, 4'd0, 12'h0, 0);           // negative -> 1
    force_val = 32'h0000_0100;
    run_add(4'd13, 4'd0, 4'd0, 12'h0, 0);           // positive -> 2
    force_en = 1'b0;

    // R6 illegal opcodes
    run_illegal(8'h00, 4'd13);
    run_illegal(8'h5B, 4'd12);

    // random mix
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(0, 3) == 0)
        gr_write(4'($urandom_range(0, 15)), $urandom());
      if ($urandom_range(0, 9) == 0) begin
        op = 8'($urandom_range(0, 255));
        if (op == ADD) op = 8'h1A;
        run_illegal(op, 4'($urandom_range(0, 15)));
      end else begin
        run_add(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                4'($urandom_range(0, 15)), 12'($urandom_range(0, 4095)),
                $urandom_range(0, 3));
      end
    end
    for (int i = 0; i < 16; i++) gr_check(4'(i), "R4 final regs");

    summary();
    $finish;
  end
endmodule